// File: doc/BRIEF.md
# Bit Shift and Bit Manipulation Unit

This block is the 16-bit shift, rotate and single-bit datapath of a processor execution stage. In one pass it rotates or shifts an operand, tests, flips, clears or sets one chosen bit, forms the one's or two's complement, and rates a 4-bit jump condition against the incoming flag word. The register file, operand fetch and memory operands sit outside the block.

The caller presents the operand, the current flags (whose carry bit also serves as carry-in), a 4-bit bit index, a 3-bit sub-operation, a 2-bit class select and a 4-bit condition code. One clock edge later the block holds the result, a fresh set of carry, zero, sign, overflow and parity flags, and a condition-true bit. Every input is sampled on every edge, so a new operation can start each cycle.

Flag word layout (input `flags_in`): bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow, bit 4 parity. Class select: 00 shift/rotate, 01 single-bit, 10 complement/negate, 11 pass-through (result is the operand, flags unchanged).

Top module: `bsu_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0. All outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R2: Shift class, sub-op 000 rotates left with bit 15 wrapping into bit 0; sub-op 010 rotates right with bit 0 wrapping into bit 15. Carry out is the bit that crossed the word edge.
- R3: Shift class, sub-op 001 rotates left through carry (carry-in enters bit 0, bit 15 becomes carry); sub-op 011 rotates right through carry (carry-in enters bit 15, bit 0 becomes carry).
- R4: Shift class, sub-ops 100 and 101 both shift left by one with 0 entering bit 0 and bit 15 going to carry; the two give identical outputs.
- R5: Shift class, sub-op 110 shifts right keeping bit 15; sub-op 111 shifts right filling bit 15 with 0. In both, bit 0 goes to carry.
- R6: For shift and one's complement, zero is set when the result is 0, sign is result bit 15, overflow is cleared, and parity is 1 when the result holds an even number of ones.
- R7: Single-bit class, sub-op [1:0]=00 (test) leaves the result equal to the operand, sets zero to the inverse of the indexed bit and passes carry, sign, overflow and parity from `flags_in`.
- R8: Single-bit class, sub-op [1:0]=01 inverts, 10 clears and 11 sets the indexed bit (index 0 to 15); all other bits are kept and all five flags pass from `flags_in`.
- R9: Complement class, sub-op [0]=0 returns the bitwise inverse of the operand; carry passes from `flags_in`.
- R10: Complement class, sub-op [0]=1 returns the two's complement; carry is set exactly when the operand is nonzero; overflow is set exactly when the operand is 0x8000 (result 0x8000); zero, sign and parity follow R6 rules.
- R11: `cond_true` reflects condition code 0000..0111 as: zero clear, zero set, sign clear, sign set, overflow clear, overflow set, parity clear, parity set, evaluated on `flags_in` in every class.
- R12: Codes 1000..1111 cover carry clear, carry set, unsigned above (carry and zero both clear), unsigned below-or-equal (carry or zero), signed greater (zero clear and sign equals overflow), signed less-or-equal (zero set or sign differs from overflow), signed greater-or-equal (sign equals overflow), signed less (sign differs from overflow).
- R13: Pass-through class returns the operand unchanged with all five flags copied from `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_class | input | 2 | Class select (shift, single-bit, complement, pass) |
| sub_op | input | 3 | Operation within the class |
| operand | input | 16 | Source word |
| bit_idx | input | 4 | Bit position for single-bit operations |
| flags_in | input | 5 | Current flags {parity, overflow, sign, zero, carry} |
| cond_code | input | 4 | Condition to evaluate |
| result | output | 16 | Registered result word |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | New zero flag |
| sign_out | output | 1 | New sign flag |
| ovf_out | output | 1 | New overflow flag |
| parity_out | output | 1 | New parity flag |
| cond_true | output | 1 | Condition code holds on `flags_in` |

## Verification
The bench aims at the word edges: rotates of 0x8001 where both end bits move, the through-carry rotates with carry-in set on a zero word, and arithmetic against logical right shift of a negative word, where a swapped fill bit shows up at once as a wrong bit 15. It negates 0x0000 and 0x8000, so a unit that sets carry on zero or misses the most-negative overflow is caught, and it tests an already-set bit and indexes 0 and 15, so an off-by-one mask or a flag update on a bit-modify is visible. All sixteen condition codes are swept over flag words chosen so that signed and unsigned orderings disagree, which exposes a swapped above/greater decode.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int WORD_W = 16;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_BIT   = 2'b01,
        CLS_UNARY = 2'b10,
        CLS_PASS  = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_FLIP = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_SET  = 2'b11
    } bit_op_e;

    // Flag word positions
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FS = 2;
    localparam int FV = 3;
    localparam int FP = 4;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              c;
        logic              z;
        logic              s;
        logic              v;
        logic              p;
        logic              ct;
    } unit_out_t;
endpackage

// File: rtl/bsu_shifter.sv
module bsu_shifter #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         cin,
    input  logic [2:0]   code,
    output logic [W-1:0] dout,
    output logic         cout
);
    always_comb begin
        dout = din;
        cout = 1'b0;
        case (code)
            3'b000: begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
            3'b001: begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
            3'b010: begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
            3'b011: begin dout = {cin, din[W-1:1]};      cout = din[0];   end
            3'b100,
            3'b101: begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
            3'b110: begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
            default: begin dout = {1'b0, din[W-1:1]};    cout = din[0];   end
        endcase
    end
endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] idx,
    input  logic [1:0]    code,
    output logic [W-1:0]  dout,
    output logic          sel_bit
);
    logic [W-1:0] mask;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (idx == IW'(i));
    end

    assign sel_bit = |(din & mask);

    always_comb begin
        case (code)
            2'b01:   dout = din ^ mask;
            2'b10:   dout = din & ~mask;
            2'b11:   dout = din | mask;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/bsu_cond.sv
module bsu_cond (
    input  logic [4:0] flags,
    input  logic [3:0] code,
    output logic       hit
);
    import bsu_pkg::*;
    logic c, z, s, v, p, lt;

    always_comb begin
        c  = flags[FC];
        z  = flags[FZ];
        s  = flags[FS];
        v  = flags[FV];
        p  = flags[FP];
        lt = s ^ v;
        case (code[3:1])
            3'b000: hit = z;
            3'b001: hit = s;
            3'b010: hit = v;
            3'b011: hit = p;
            3'b100: hit = c;
            3'b101: hit = c | z;
            3'b110: hit = z | lt;
            default: hit = lt;
        endcase
        // even codes are the negated sense of the odd partner
        if (!code[0]) hit = ~hit;
    end
endmodule

// File: rtl/bsu_unit.sv
module bsu_unit
    import bsu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_class,
    input  logic [2:0]    sub_op,
    input  logic [W-1:0]  operand,
    input  logic [IW-1:0] bit_idx,
    input  logic [4:0]    flags_in,
    input  logic [3:0]    cond_code,
    output logic [W-1:0]  result,
    output logic          carry_out,
    output logic          zero_out,
    output logic          sign_out,
    output logic          ovf_out,
    output logic          parity_out,
    output logic          cond_true
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         c;
        logic         z;
        logic         s;
        logic         v;
        logic         p;
        logic         ct;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] sh_res, bo_res;
    logic         sh_c, bo_sel, cond_hit;
    logic [W-1:0] neg_res;

    bsu_shifter #(.W(W)) u_shift (
        .din (operand),
        .cin (flags_in[FC]),
        .code(sub_op),
        .dout(sh_res),
        .cout(sh_c)
    );

    bsu_bitop #(.W(W), .IW(IW)) u_bitop (
        .din    (operand),
        .idx    (bit_idx),
        .code   (sub_op[1:0]),
        .dout   (bo_res),
        .sel_bit(bo_sel)
    );

    bsu_cond u_cond (
        .flags(flags_in),
        .code (cond_code),
        .hit  (cond_hit)
    );

    assign neg_res = (~operand) + W'(1);

    always_comb begin
        st_d    = '0;
        st_d.res = operand;
        st_d.c  = flags_in[FC];
        st_d.z  = flags_in[FZ];
        st_d.s  = flags_in[FS];
        st_d.v  = flags_in[FV];
        st_d.p  = flags_in[FP];
        st_d.ct = cond_hit;
        case (op_class_e'(op_class))
            CLS_SHIFT: begin
                st_d.res = sh_res;
                st_d.c   = sh_c;
                st_d.v   = 1'b0;
                st_d.z   = (sh_res == '0);
                st_d.s   = sh_res[W-1];
                st_d.p   = ~(^sh_res);
            end
            CLS_BIT: begin
                st_d.res = bo_res;
                if (bit_op_e'(sub_op[1:0]) == BOP_TEST) st_d.z = ~bo_sel;
            end
            CLS_UNARY: begin
                if (sub_op[0]) begin
                    st_d.res = neg_res;
                    st_d.c   = (operand != '0);
                    st_d.v   = (operand == {1'b1, {(W-1){1'b0}}});
                end else begin
                    st_d.res = ~operand;
                    st_d.v   = 1'b0;
                end
                st_d.z = (st_d.res == '0);
                st_d.s = st_d.res[W-1];
                st_d.p = ~(^st_d.res);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result     = st_q.res;
    assign carry_out  = st_q.c;
    assign zero_out   = st_q.z;
    assign sign_out   = st_q.s;
    assign ovf_out    = st_q.v;
    assign parity_out = st_q.p;
    assign cond_true  = st_q.ct;

    // Assertions
    assert_shl_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b00 && sub_op[2:1] == 2'b10)
        |=> (result[0] == 1'b0 && carry_out == $past(operand[W-1])));

    assert_set_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b01 && sub_op[1:0] == 2'b11) |=> result[$past(bit_idx)]);

    assert_clr_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b01 && sub_op[1:0] == 2'b10) |=> !result[$past(bit_idx)]);

    assert_test_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b01 && sub_op[1:0] == 2'b00) |=> (result == $past(operand)));

    assert_neg_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && sub_op[0] && operand == {1'b1, {(W-1){1'b0}}})
        |=> (ovf_out && result == {1'b1, {(W-1){1'b0}}}));

    assert_shift_novf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b00) |=> !ovf_out);

    assert_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11) |=> (result == $past(operand) && carry_out == $past(flags_in[0])));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (result == '0 && !cond_true));
endmodule

// File: tb/bsu_unit_tb.sv
module bsu_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = '0;
    logic [2:0]  sub_op = '0;
    logic [15:0] operand = '0;
    logic [3:0]  bit_idx = '0;
    logic [4:0]  flags_in = '0;
    logic [3:0]  cond_code = '0;
    logic [15:0] result;
    logic carry_out, zero_out, sign_out, ovf_out, parity_out, cond_true;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bsu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .sub_op(sub_op),
        .operand(operand), .bit_idx(bit_idx), .flags_in(flags_in),
        .cond_code(cond_code), .result(result), .carry_out(carry_out),
        .zero_out(zero_out), .sign_out(sign_out), .ovf_out(ovf_out),
        .parity_out(parity_out), .cond_true(cond_true)
    );

    // got/exp packed as {result, p, v, s, z, c}
    task automatic check(input string tag, input logic [20:0] got, input logic [20:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [1:0] cls, input logic [2:0] op, input logic [15:0] x,
                       input logic [3:0] idx, input logic [4:0] fl, input logic [3:0] cc);
        @(negedge clk);
        op_class = cls; sub_op = op; operand = x; bit_idx = idx; flags_in = fl; cond_code = cc;
        @(negedge clk);
    endtask

    function automatic logic [20:0] outs();
        return {result, parity_out, ovf_out, sign_out, zero_out, carry_out};
    endfunction

    function automatic logic [20:0] mk(input logic [15:0] r, input logic p, input logic v,
                                        input logic s, input logic z, input logic c);
        return {r, p, v, s, z, c};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset", {outs()}, 21'd0);
        check("R1 reset cond", {20'd0, cond_true}, 21'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_rotate();
        run(2'b00, 3'b000, 16'h8001, 0, 5'b00000, 0);
        check("R2 rol", outs(), mk(16'h0003, 1, 0, 0, 0, 1));
        run(2'b00, 3'b010, 16'h8001, 0, 5'b00000, 0);
        check("R2 ror", outs(), mk(16'hC000, 1, 0, 1, 0, 1));
        run(2'b00, 3'b001, 16'h8001, 0, 5'b00000, 0);
        check("R3 rolc cin0", outs(), mk(16'h0002, 0, 0, 0, 0, 1));
        run(2'b00, 3'b011, 16'h8001, 0, 5'b00000, 0);
        check("R3 rorc cin0", outs(), mk(16'h4000, 0, 0, 0, 0, 1));
        run(2'b00, 3'b001, 16'h0000, 0, 5'b00001, 0);
        check("R3 rolc cin1", outs(), mk(16'h0001, 0, 0, 0, 0, 0));
        run(2'b00, 3'b011, 16'h0000, 0, 5'b00001, 0);
        check("R3 rorc cin1", outs(), mk(16'h8000, 0, 0, 1, 0, 0));
    endtask

    task automatic t_shift();
        run(2'b00, 3'b100, 16'h8001, 0, 5'b01000, 0);
        check("R4 sla", outs(), mk(16'h0002, 0, 0, 0, 0, 1));
        run(2'b00, 3'b101, 16'h8001, 0, 5'b01000, 0);
        check("R4 sll", outs(), mk(16'h0002, 0, 0, 0, 0, 1));
        run(2'b00, 3'b110, 16'h8001, 0, 5'b00000, 0);
        check("R5 sra", outs(), mk(16'hC000, 1, 0, 1, 0, 1));
        run(2'b00, 3'b111, 16'h8001, 0, 5'b00000, 0);
        check("R5 srl", outs(), mk(16'h4000, 0, 0, 0, 0, 1));
        run(2'b00, 3'b111, 16'h0001, 0, 5'b01000, 0);
        check("R6 srl to zero", outs(), mk(16'h0000, 1, 0, 0, 1, 1));
    endtask

    task automatic t_bits();
        run(2'b01, 3'b000, 16'h00F0, 4, 5'b10101, 0);
        check("R7 test set bit", outs(), mk(16'h00F0, 1, 0, 1, 0, 1));
        run(2'b01, 3'b000, 16'h00F0, 3, 5'b10101, 0);
        check("R7 test clear bit", outs(), mk(16'h00F0, 1, 0, 1, 1, 1));
        run(2'b01, 3'b001, 16'h00F0, 15, 5'b10101, 0);
        check("R8 flip b15", outs(), mk(16'h80F0, 1, 0, 1, 0, 1));
        run(2'b01, 3'b010, 16'h00F0, 4, 5'b01010, 0);
        check("R8 clear b4", outs(), mk(16'h00E0, 0, 1, 0, 1, 0));
        run(2'b01, 3'b011, 16'h00F0, 0, 5'b10101, 0);
        check("R8 set b0", outs(), mk(16'h00F1, 1, 0, 1, 0, 1));
        run(2'b01, 3'b011, 16'h00F0, 4, 5'b10101, 0);
        check("R8 set already set", outs(), mk(16'h00F0, 1, 0, 1, 0, 1));
    endtask

    task automatic t_unary();
        run(2'b10, 3'b000, 16'h00FF, 0, 5'b01001, 0);
        check("R9 cpl", outs(), mk(16'hFF00, 1, 0, 1, 0, 1));
        run(2'b10, 3'b001, 16'h0001, 0, 5'b00000, 0);
        check("R10 neg 1", outs(), mk(16'hFFFF, 1, 0, 1, 0, 1));
        run(2'b10, 3'b001, 16'h0000, 0, 5'b00001, 0);
        check("R10 neg 0", outs(), mk(16'h0000, 1, 0, 0, 1, 0));
        run(2'b10, 3'b001, 16'h8000, 0, 5'b00000, 0);
        check("R10 neg min", outs(), mk(16'h8000, 0, 1, 1, 0, 1));
    endtask

    // expected condition from the R11/R12 table; flags {p,v,s,z,c}
    function automatic logic exp_cond(input logic [4:0] f, input logic [3:0] cc);
        logic c, z, s, v, p;
        c = f[0]; z = f[1]; s = f[2]; v = f[3]; p = f[4];
        case (cc)
            4'd0:  return !z;           4'd1:  return z;
            4'd2:  return !s;           4'd3:  return s;
            4'd4:  return !v;           4'd5:  return v;
            4'd6:  return !p;           4'd7:  return p;
            4'd8:  return !c;           4'd9:  return c;
            4'd10: return !c && !z;     4'd11: return c || z;
            4'd12: return !z && (s == v); 4'd13: return z || (s != v);
            4'd14: return s == v;       default: return s != v;
        endcase
    endfunction

    task automatic t_cond();
        logic [4:0] fsets [6];
        fsets = '{5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01100, 5'b11011};
        foreach (fsets[k]) begin
            for (int cc = 0; cc < 16; cc++) begin
                run(2'b11, 3'b000, 16'h1234, 0, fsets[k], cc[3:0]);
                if (cc < 8)
                    check("R11 cond", {20'd0, cond_true}, {20'd0, exp_cond(fsets[k], cc[3:0])});
                else
                    check("R12 cond", {20'd0, cond_true}, {20'd0, exp_cond(fsets[k], cc[3:0])});
            end
            check("R13 pass", outs(), {16'h1234, fsets[k]});
        end
        // condition also valid during a shift
        run(2'b00, 3'b000, 16'h0001, 0, 5'b00110, 4'd12);
        check("R12 G during shift", {20'd0, cond_true}, 21'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_rotate();
                t_shift();
                t_bits();
                t_unary();
                t_cond();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule